// File: doc/BRIEF.md
# Shift and Rotate Unit with Extend Flag

This block moves an operand left or right by a given number of positions and keeps a small condition code register beside the result. It handles eight operations: arithmetic and logical shifts in both directions, plain rotates, and rotates whose ring includes a separate extend bit. The operand may be treated as 8, 16 or 32 bits wide. Only the low bits selected by the size take part in the operation. The bits above them are passed through as they are.

A write strobe stores the computed result and the new flags in registers. While the strobe is low both registers keep their values. The extend bit held in the flag register is the bit that the extend rotates feed in. A sequence of operations can therefore carry a bit from one operand into the next.

Top module: `shrot_unit`

## Requirements
- R1: After reset, `result` and `ccr` are all zeros.
- R2: While `we` is low, `result` and `ccr` hold their values. When `we` is high, both take the new values at the next rising clock edge.
- R3: The `op` codes are 0 ASL, 1 ASR, 2 LSL, 3 LSR, 4 ROL, 5 ROR, 6 ROXL and 7 ROXR. LSL fills with zeros from the bottom and LSR fills with zeros from the top. C is the last bit shifted out. It is 0 once the count exceeds the width.
- R4: ASR fills from the top with the sign bit, so C becomes the sign once the count reaches the width. ASL moves bits like LSL and sets V when the top bit changes value at any step of the shift.
- R5: Every operation other than ASL clears V.
- R6: ROL and ROR rotate within the operand width, with count taken modulo the width. C is the last bit carried around, and X is left unchanged.
- R7: ROXL and ROXR rotate a ring of width+1 bits, formed from X above the operand. X and C both end up holding the last bit moved out.
- R8: For the four shift operations with a nonzero count, X is set equal to C.
- R9: A zero count leaves the sized operand unchanged and keeps X. It clears C, except for ROXL and ROXR, where C takes the value of X.
- R10: N is the top bit of the sized result. Z is 1 exactly when the sized result is zero.
- R11: `size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Result bits above the selected width equal the operand bits.
- R12: The layout of `ccr` is bit 0 C, bit 1 V, bit 2 Z, bit 3 N and bit 4 X. Bits 7:5 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Commit strobe for the result and the flags |
| op | input | 3 | Operation code |
| size | input | 2 | Operand size select |
| operand | input | 32 | Value to shift or rotate |
| count | input | CNT_W (6) | Number of positions, from 0 to 63 |
| result | output | 32 | Registered result |
| ccr | output | 8 | Registered condition codes |

## Verification
At byte size, every operand value is run through every operation. The counts used are 0 to 9, 15, 16 and 63. These counts reach the edges that tell the operations apart: zero, one below and one above the width, the width plus one for the extend ring, and counts far past the width. The upper operand bits carry varied patterns, which exposes any leak across the size boundary. At word and long size, operands, counts and operations come from a pseudo-random sequence. Because the carried-in extend bit depends on the previous operation, the extend rotates see both X values. Idle cycles with busy inputs separate a held register from one that follows its inputs.

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       op,
  input  logic [1:0]       size,
  input  logic [31:0]      operand,
  input  logic [CNT_W-1:0] count,
  output logic [31:0]      result,
  output logic [7:0]       ccr
);
  localparam int STEPS = 1 << CNT_W;
  localparam logic [2:0] OP_ASL  = 3'd0;
  localparam logic [2:0] OP_ASR  = 3'd1;
  localparam logic [2:0] OP_LSL  = 3'd2;
  localparam logic [2:0] OP_LSR  = 3'd3;
  localparam logic [2:0] OP_ROL  = 3'd4;
  localparam logic [2:0] OP_ROR  = 3'd5;
  localparam logic [2:0] OP_ROXL = 3'd6;
  localparam logic [2:0] OP_ROXR = 3'd7;

  function automatic logic [31:0] size_mask(input logic [1:0] s);
    case (s)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic top_bit(input logic [31:0] v, input logic [1:0] s);
    case (s)
      2'd0:    return v[7];
      2'd1:    return v[15];
      default: return v[31];
    endcase
  endfunction

  function automatic logic [31:0] put_top(input logic [31:0] v, input logic [1:0] s, input logic b);
    logic [31:0] r;
    r = v;
    case (s)
      2'd0:    r[7]  = b;
      2'd1:    r[15] = b;
      default: r[31] = b;
    endcase
    return r;
  endfunction

  logic [31:0] mask, work, res;
  logic        hi, lo, cy, xr, ovf, c_fin, x_fin;
  logic [7:0]  flags;

  assign mask = size_mask(size);

  always_comb begin
    work = operand & mask;
    xr   = ccr[4];
    cy   = 1'b0;
    ovf  = 1'b0;
    hi   = 1'b0;
    lo   = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (i < int'(count)) begin
        hi = top_bit(work, size);
        lo = work[0];
        case (op)
          OP_ASL, OP_LSL: begin
            cy   = hi;
            work = work << 1;
            if (op == OP_ASL && top_bit(work, size) != hi) ovf = 1'b1;
          end
          OP_ASR:  begin cy = lo; work = put_top(work >> 1, size, hi);   end
          OP_LSR:  begin cy = lo; work = put_top(work >> 1, size, 1'b0); end
          OP_ROL:  begin cy = hi; work = {work[30:0], hi};               end
          OP_ROR:  begin cy = lo; work = put_top(work >> 1, size, lo);   end
          OP_ROXL: begin cy = hi; work = {work[30:0], xr}; xr = hi;      end
          OP_ROXR: begin cy = lo; work = put_top(work >> 1, size, xr); xr = lo; end
          default: ;
        endcase
      end
    end
  end

  assign res = (operand & ~mask) | (work & mask);

  always_comb begin
    if (op[2:1] == 2'b11) begin
      c_fin = xr;
      x_fin = xr;
    end else if (op[2]) begin
      c_fin = cy;
      x_fin = ccr[4];
    end else begin
      c_fin = cy;
      x_fin = (count != '0) ? cy : ccr[4];
    end
  end

  assign flags = {3'b000, x_fin, top_bit(res, size), (res & mask) == 32'd0, ovf, c_fin};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      ccr    <= '0;
    end else if (we) begin
      result <= res;
      ccr    <= flags;
    end
  end
endmodule

module shrot_unit_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we,
  input logic [2:0]       op,
  input logic [1:0]       size,
  input logic [31:0]      operand,
  input logic [CNT_W-1:0] count,
  input logic [31:0]      result,
  input logic [7:0]       ccr
);
  function automatic logic [31:0] msk(input logic [1:0] s);
    case (s)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !we |=> $stable(result) && $stable(ccr)); // R2
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) we |=> ccr[7:5] == 3'b000); // R12
  AST_ROT_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n) (we && op[2:1] == 2'b10) |=> ccr[4] == $past(ccr[4])); // R6
  AST_V_ONLY_ASL: assert property (@(posedge clk) disable iff (!rst_n) (we && op != 3'd0) |=> !ccr[1]); // R5
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (we && count == '0 && op[2:1] != 2'b11) |=> result == $past(operand) && !ccr[0]); // R9
  AST_ROX_ZERO_C: assert property (@(posedge clk) disable iff (!rst_n) (we && count == '0 && op[2:1] == 2'b11) |=> ccr[0] == $past(ccr[4])); // R9
  AST_SHIFT_X_EQ_C: assert property (@(posedge clk) disable iff (!rst_n) (we && !op[2] && count != '0) |=> ccr[4] == ccr[0]); // R8
  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n) we |=> ((result ^ $past(operand)) & ~msk($past(size))) == 32'd0); // R11
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) we |=> ccr[2] == ((result & msk($past(size))) == 32'd0)); // R10
endmodule

bind shrot_unit shrot_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .op(op), .size(size),
  .operand(operand), .count(count), .result(result), .ccr(ccr)
);

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] operand = '0;
  logic [5:0]  count = '0;
  logic [31:0] result;
  logic [7:0]  ccr;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_res = '0;
  logic [7:0]  m_ccr = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  shrot_unit u_dut (.clk(clk), .rst_n(rst_n), .we(we), .op(op), .size(size),
                    .operand(operand), .count(count), .result(result), .ccr(ccr));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic string optag(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R4";
      3'd2, 3'd3: return "R3";
      3'd4, 3'd5: return "R6";
      default:    return "R7";
    endcase
  endfunction

  function automatic logic [39:0] model(input logic [2:0] o, input logic [1:0] s,
                                        input logic [31:0] a, input int n, input logic xin);
    int w, k;
    logic [127:0] m, m1, v, r, sv, ring, rr, t, fm, fld;
    logic c, x, vf;
    logic [31:0] full;
    w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m = (128'd1 << w) - 128'd1;
    m1 = (128'd1 << (w + 1)) - 128'd1;
    v = {96'd0, a} & m;
    c = 1'b0; x = xin; vf = 1'b0; r = '0;
    case (o)
      3'd0, 3'd2: begin
        r = (v << n) & m;
        if (n > 0 && n <= w) c = v[w-n];
        if (o == 3'd0) begin
          t = v << 64;
          fm = (128'd1 << (n + 1)) - 128'd1;
          fld = (t >> (w - 1 + 64 - n)) & fm;
          vf = (fld != '0) && (fld != fm);
        end
        if (n > 0) x = c;
      end
      3'd1: begin
        sv = v[w-1] ? (v | ~m) : v;
        r = (sv >> n) & m;
        if (n > 0) begin c = sv[n-1]; x = c; end
      end
      3'd3: begin
        r = v >> n;
        if (n > 0 && n <= w) c = v[n-1];
        if (n > 0) x = c;
      end
      3'd4: begin
        k = n % w;
        r = ((v << k) | (v >> (w - k))) & m;
        if (n > 0) c = r[0];
      end
      3'd5: begin
        k = n % w;
        r = ((v >> k) | (v << (w - k))) & m;
        if (n > 0) c = r[w-1];
      end
      default: begin
        ring = ({127'd0, xin} << w) | v;
        k = n % (w + 1);
        if (o == 3'd6) rr = ((ring << k) | (ring >> (w + 1 - k))) & m1;
        else           rr = ((ring >> k) | (ring << (w + 1 - k))) & m1;
        r = rr & m;
        x = rr[w];
        c = x;
      end
    endcase
    full = (a & ~m[31:0]) | r[31:0];
    return {3'b000, x, r[w-1], (r == '0), vf, c, full};
  endfunction

  task automatic check_out(input logic [31:0] er, input logic [7:0] ec, input string tr, input string tc);
    checks++;
    if (result !== er) begin
      fails++;
      $display("FAIL %s result: got %h expected %h", tr, result, er);
    end
    checks++;
    if (ccr !== ec) begin
      fails++;
      $display("FAIL %s ccr: got %b expected %b", tc, ccr, ec);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic [31:0] a, input int n);
    logic [39:0] e;
    e = model(o, s, a, n, m_ccr[4]);
    we = 1'b1; op = o; size = s; operand = a; count = n[5:0];
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    check_out(e[31:0], e[39:32], {optag(o), " R11", (n == 0) ? " R9" : ""}, "R12 R10 R8 R9 R5");
    m_res = e[31:0];
    m_ccr = e[39:32];
  endtask

  task automatic idle_busy();
    seed = nxt(seed);
    we = 1'b0; op = seed[2:0]; size = seed[4:3]; operand = nxt(seed); count = seed[10:5];
    @(posedge clk);
    @(negedge clk);
    check_out(m_res, m_ccr, "R2", "R2");
  endtask

  function automatic int byte_cnt(input int ci);
    if (ci < 10) return ci;
    if (ci == 10) return 15;
    if (ci == 11) return 16;
    return 63;
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out(32'd0, 8'd0, "R1", "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_out(32'd0, 8'd0, "R1", "R1");

    for (int o = 0; o < 8; o++) begin
      for (int a = 0; a < 256; a++) begin
        for (int ci = 0; ci < 13; ci++) begin
          seed = nxt(seed);
          apply(o[2:0], 2'd0, {seed[31:8], a[7:0]}, byte_cnt(ci));
        end
      end
      for (int h = 0; h < 4; h++) idle_busy();
    end

    for (int j = 0; j < 6000; j++) begin
      logic [31:0] a;
      seed = nxt(seed);
      a = nxt(seed);
      if (seed[25:24] == 2'b00) a = 32'd0;
      apply(seed[2:0], (j % 3 == 0) ? 2'd1 : (j % 3 == 1) ? 2'd2 : 2'd3, a,
            seed[20] ? int'(seed[9:5] & 5'd17) : int'(seed[15:10]));
      if (j % 500 == 0) idle_busy();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule